// File: doc/BRIEF.md
# Two-wire command front end

This block is the serial side of a small mixed-signal control part. It listens on a two-wire bus as a slave. SCL is an input and SDA is open-drain: the block pulls the line low through an enable and never drives it high. A transaction opens with a START. The first byte names the part: a fixed device-type nibble, followed by four bits that must equal the board strap pins. The second byte carries a 4-bit opcode and two 2-bit pointers. One pointer picks one of four data registers. The other picks one of two potentiometers or one of two comparators. Depending on the opcode, a third byte follows. The master either sends six bits of data, or the block returns six bits that it reads from the register bank.

The block decodes the opcode and presents the opcode, both pointers and any write data to the register bank on its own outputs. A command is handed over by a single-cycle strobe, and only when the master closes the transfer with a STOP. While the bank reports a nonvolatile write in progress, the block declines to acknowledge its own address. The master keeps addressing the part until the acknowledge comes back. SCL and SDA are expected to arrive already synchronised and free of glitches.

Top module: `twi_cmd_frontend`

## Requirements
- R1: After reset, sda_oe and cmd_valid are low.
- R2: The block acknowledges an address byte equal to {4'b0101, strap[3:0]}, sent MSB first, when nv_busy is low. It acknowledges by raising sda_oe during the ninth clock of the byte, and it raises sda_oe only while SCL is low.
- R3: The block never acknowledges an address byte whose type nibble or strap bits differ. After such a byte, it ignores every later byte and STOP until the next START.
- R4: While nv_busy is high, a matching address byte is not acknowledged.
- R5: The block always acknowledges the instruction byte. Its bits [7:4] give cmd_op, bits [3:2] give cmd_reg and bits [1:0] give cmd_pot.
- R6: Opcodes 4'b1010 and 4'b1100 take one data byte, which the block acknowledges. cmd_wdata takes the low six bits of that byte, and the top two bits are ignored.
- R7: For opcodes 4'b1001 and 4'b1011, the block sends {2'b00, rd_data} MSB first. Each bit changes after SCL falls. The block releases SDA for the master's acknowledge in the ninth clock. A read produces no cmd_valid.
- R8: Every other opcode ends after the instruction byte and its acknowledge.
- R9: cmd_valid is raised only by a STOP that closes a complete write or two-byte command. A START during a transfer discards the pending command and restarts address reception.
- R10: Bus traffic seen before any START is ignored, and nothing is acknowledged.
- R11: cmd_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line |
| sda_oe | output | 1 | Pulls SDA low when high |
| strap | input | 4 | Board-level address straps |
| nv_busy | input | 1 | Nonvolatile write in progress |
| rd_data | input | 6 | Read value from the register bank for the selected register |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Decoded opcode |
| cmd_reg | output | 2 | Data-register pointer |
| cmd_pot | output | 2 | Potentiometer or comparator pointer |
| cmd_wdata | output | 6 | Write data |

## Verification
Before any START, the bench clocks a byte identical to the correct address. A block that is not gated on START would acknowledge it. It then tries a wrong strap, a wrong type nibble and a busy part. A slave that leaks out of its idle state would acknowledge the trailing byte, or would strobe a command on the STOP that follows. Reads are checked bit by bit on the wired line, and SDA must be released in the ninth clock. An off-by-one in the bit counter shows up either as a shifted value or as the master's acknowledge slot being blocked. A repeated START is issued after an acknowledged write instruction, and only the command that follows it may reach the register bank.

// File: rtl/twi_fe_pkg.sv
package twi_fe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {K_SHORT, K_WRITE, K_READ} kind_e;

  // command length class from the opcode
  function automatic kind_e op_kind(input logic [3:0] op);
    kind_e k;
    case (op)
      4'b1001, 4'b1011: k = K_READ;
      4'b1010, 4'b1100: k = K_WRITE;
      default:          k = K_SHORT;
    endcase
    return k;
  endfunction

  // address match: type nibble then straps
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [3:0] tid,
                                    input logic [3:0] pins);
    return b == {tid, pins};
  endfunction

  // outgoing frame for a 6-bit register value
  function automatic logic [BYTE_W-1:0] tx_frame(input logic [5:0] d);
    return {2'b00, d};
  endfunction
endpackage

// File: rtl/twi_fe_events.sv
module twi_fe_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic rise,
  output logic fall,
  output logic start,
  output logic stop
);
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      scl_p <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i;
      scl_p <= scl_q;
      sda_q <= sda_i;
      sda_p <= sda_q;
    end
  end

  assign scl_s = scl_q;
  assign sda_s = sda_q;
  assign rise  = scl_q & ~scl_p;
  assign fall  = ~scl_q & scl_p;
  // data edges while the clock stays high are bus conditions
  assign start = scl_q & scl_p & sda_p & ~sda_q;
  assign stop  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/twi_fe_shift.sv
module twi_fe_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], in_bit};
  end
endmodule

// File: rtl/twi_cmd_frontend.sv
module twi_cmd_frontend
  import twi_fe_pkg::*;
#(
  parameter logic [3:0] TYPE_ID = 4'b0101,
  parameter int STRAP_W = 4,
  parameter int OP_W    = 4,
  parameter int SEL_W   = 2,
  parameter int DATA_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic               nv_busy,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               cmd_valid,
  output logic [OP_W-1:0]    cmd_op,
  output logic [SEL_W-1:0]   cmd_reg,
  output logic [SEL_W-1:0]   cmd_pot,
  output logic [DATA_W-1:0]  cmd_wdata
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_W + 1);

  logic scl_s, sda_s, rise, fall, start, stop;
  logic [BYTE_W-1:0] sr;
  phase_e ph;
  logic [CNT_W-1:0] cnt;
  logic pend;

  twi_fe_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .rise(rise), .fall(fall),
    .start(start), .stop(stop)
  );

  // named internal events
  logic is_rx, bit_in, bit_out, ack_decide, ack_end, addr_decide, byte_ok, rd_load;
  logic [BYTE_W-1:0] rd_frame;
  assign is_rx       = (ph == PH_ADDR) || (ph == PH_INSTR) || (ph == PH_WDATA);
  assign bit_in      = rise && is_rx && (cnt < CNT_ACK);
  assign bit_out     = fall && (ph == PH_RDATA) && (cnt != '0) && (cnt < CNT_ACK);
  assign ack_decide  = fall && is_rx && (cnt == CNT_ACK);
  assign ack_end     = fall && (cnt == CNT_DONE);
  assign addr_decide = ack_decide && (ph == PH_ADDR);
  assign byte_ok     = (ph != PH_ADDR) || (addr_hit(sr, TYPE_ID, strap) && !nv_busy);
  assign rd_load     = ack_end && (ph == PH_INSTR) && (op_kind(cmd_op) == K_READ);
  assign rd_frame    = tx_frame(rd_data);

  twi_fe_shift #(.W(BYTE_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(rd_frame),
    .shift(bit_in | bit_out), .in_bit(bit_in & sda_s), .q(sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      sda_oe    <= 1'b0;
      pend      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_reg   <= '0;
      cmd_pot   <= '0;
      cmd_wdata <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start) begin
        ph     <= PH_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        pend   <= 1'b0;
      end else if (stop) begin
        if (pend && ph == PH_HOLD) cmd_valid <= 1'b1;
        ph     <= PH_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        pend   <= 1'b0;
      end else if (ph != PH_IDLE && ph != PH_HOLD) begin
        if (rise) begin
          if (cnt < CNT_ACK)       cnt <= cnt + 1'b1;
          else if (cnt == CNT_ACK) cnt <= CNT_DONE;
        end else if (fall) begin
          if (ph == PH_RDATA) begin
            if (bit_out)              sda_oe <= ~sr[BYTE_W-2];
            else if (cnt == CNT_ACK)  sda_oe <= 1'b0;
            else if (cnt == CNT_DONE) ph <= PH_HOLD;
          end else if (cnt == CNT_ACK) begin
            if (byte_ok) begin
              sda_oe <= 1'b1;
              if (ph == PH_INSTR) begin
                cmd_op  <= sr[7:4];
                cmd_reg <= sr[3:2];
                cmd_pot <= sr[1:0];
              end
              if (ph == PH_WDATA) cmd_wdata <= sr[DATA_W-1:0];
            end else begin
              ph <= PH_IDLE;
            end
          end else if (cnt == CNT_DONE) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            case (ph)
              PH_ADDR:  ph <= PH_INSTR;
              PH_INSTR: begin
                case (op_kind(cmd_op))
                  K_READ: begin
                    ph     <= PH_RDATA;
                    sda_oe <= ~rd_frame[BYTE_W-1];
                  end
                  K_WRITE: ph <= PH_WDATA;
                  default: begin
                    ph   <= PH_HOLD;
                    pend <= 1'b1;
                  end
                endcase
              end
              default: begin
                ph   <= PH_HOLD;
                pend <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  // checks beside the logic they guard
  assert_busy_noack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_decide && nv_busy |=> !sda_oe);
  assert_addr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_decide && !nv_busy && addr_hit(sr, TYPE_ID, strap) |=> sda_oe);
  assert_drive_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_IDLE |-> !sda_oe);
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ph == PH_ADDR && cnt == '0 && !sda_oe && !pend));
  assert_valid_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(stop));
  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall && ph == PH_RDATA && cnt == CNT_ACK |=> !sda_oe);
endmodule

// File: tb/sim_twi_cmd_frontend.sv
`timescale 1ns/1ps
module sim_twi_cmd_frontend;
  localparam int HP = 8;
  localparam logic [3:0] STRAPS = 4'hA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic nv_busy = 1'b0;
  logic sda_oe, cmd_valid;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [5:0] cmd_wdata, rd_data;
  logic line;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [14:0] expq[$];
  logic prev_v = 1'b0;

  always #5 clk = ~clk;

  assign line = sda_m & ~sda_oe;

  // bench-side register bank contents
  function automatic logic [5:0] bank_val(input logic [1:0] r, input logic [1:0] p);
    return {p, r, 2'b11} ^ 6'b010101;
  endfunction
  assign rd_data = bank_val(cmd_reg, cmd_pot);

  twi_cmd_frontend u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .strap(STRAPS), .nv_busy(nv_busy), .rd_data(rd_data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: every strobe is matched against the expected command queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        check(!prev_v, "R11", 1, 0);
        if (expq.size() == 0) begin
          check(1'b0, "R9", 1, 0);
        end else begin
          logic [14:0] e;
          e = expq.pop_front();
          check({cmd_op, cmd_reg, cmd_pot} == e[13:6], e[14] ? "R6" : "R8",
                int'({cmd_op, cmd_reg, cmd_pot}), int'(e[13:6]));
          if (e[14]) check(cmd_wdata == e[5:0], "R6", int'(cmd_wdata), int'(e[5:0]));
        end
      end
      prev_v = cmd_valid;
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; waitc(HP);
    scl = 1'b1;   waitc(HP);
    sda_m = 1'b0; waitc(HP);
    scl = 1'b0;   waitc(HP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(HP);
    scl = 1'b1;   waitc(HP);
    sda_m = 1'b1; waitc(HP);
  endtask

  // master sends a byte; checks slave ack and the line state after the ack
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit exp_after,
                           input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(HP);
      scl = 1'b1;   waitc(HP);
      scl = 1'b0;
    end
    sda_m = 1'b1; waitc(HP);
    check(sda_oe == exp_ack, tag, int'(sda_oe), int'(exp_ack));
    scl = 1'b1; waitc(HP);
    check(sda_oe == exp_ack, tag, int'(sda_oe), int'(exp_ack));
    scl = 1'b0; waitc(HP);
    check(sda_oe == exp_after, tag, int'(sda_oe), int'(exp_after));
  endtask

  // master reads a byte and answers with no-ack
  task automatic recv_byte(input logic [7:0] exp);
    for (int i = 7; i >= 0; i--) begin
      check(line == exp[i], "R7", int'(line), int'(exp[i]));
      scl = 1'b1; waitc(HP);
      scl = 1'b0; waitc(HP);
    end
    check(sda_oe == 1'b0, "R7", int'(sda_oe), 0);
    scl = 1'b1; waitc(HP);
    scl = 1'b0; waitc(HP);
  endtask

  task automatic expect_after_stop(input int n, input string tag);
    waitc(4);
    check(expq.size() == n, tag, expq.size(), n);
  endtask

  initial begin : watchdog
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    waitc(5);
    check(sda_oe == 1'b0 && cmd_valid == 1'b0, "R1", int'({sda_oe, cmd_valid}), 0);
    rst_n = 1'b1;
    waitc(5);
    check(sda_oe == 1'b0 && cmd_valid == 1'b0, "R1", int'({sda_oe, cmd_valid}), 0);

    // R10: a matching address clocked before any START
    scl = 1'b0; waitc(HP);
    send_byte(8'h5A, 1'b0, 1'b0, "R10");
    send_byte(8'hA6, 1'b0, 1'b0, "R10");
    bus_stop();
    expect_after_stop(0, "R10");

    // R2 R5 R6: write with data byte
    expq.push_back({1'b1, 4'hA, 2'b01, 2'b10, 6'h2D});
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R2");
    send_byte(8'hA6, 1'b1, 1'b0, "R5");
    send_byte(8'h2D, 1'b1, 1'b0, "R6");
    bus_stop();
    expect_after_stop(0, "R6");

    // R6: upper two data bits ignored
    expq.push_back({1'b1, 4'hC, 2'b11, 2'b01, 6'h05});
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R2");
    send_byte(8'hCD, 1'b1, 1'b0, "R5");
    send_byte(8'hC5, 1'b1, 1'b0, "R6");
    bus_stop();
    expect_after_stop(0, "R6");

    // R7: two reads, no strobe
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R2");
    send_byte(8'h9B, 1'b1, 1'b1, "R7");
    recv_byte({2'b00, bank_val(2'b10, 2'b11)});
    bus_stop();
    expect_after_stop(0, "R7");
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R2");
    send_byte(8'hB4, 1'b1, 1'b1, "R7");
    recv_byte({2'b00, bank_val(2'b01, 2'b00)});
    bus_stop();
    expect_after_stop(0, "R7");

    // R8: two-byte transfer command
    expq.push_back({1'b0, 4'hD, 2'b00, 2'b01, 6'h00});
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R2");
    send_byte(8'hD1, 1'b1, 1'b0, "R8");
    bus_stop();
    expect_after_stop(0, "R8");

    // R3: wrong straps, then wrong type nibble
    bus_start();
    send_byte(8'h5B, 1'b0, 1'b0, "R3");
    send_byte(8'hA6, 1'b0, 1'b0, "R3");
    send_byte(8'h11, 1'b0, 1'b0, "R3");
    bus_stop();
    expect_after_stop(0, "R3");
    bus_start();
    send_byte(8'h7A, 1'b0, 1'b0, "R3");
    send_byte(8'hD1, 1'b0, 1'b0, "R3");
    bus_stop();
    expect_after_stop(0, "R3");

    // R4: busy withholds ack; poll until it returns
    nv_busy = 1'b1;
    bus_start();
    send_byte(8'h5A, 1'b0, 1'b0, "R4");
    send_byte(8'h11, 1'b0, 1'b0, "R4");
    bus_stop();
    expect_after_stop(0, "R4");
    nv_busy = 1'b0;
    expq.push_back({1'b0, 4'h1, 2'b00, 2'b00, 6'h00});
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R4");
    send_byte(8'h10, 1'b1, 1'b0, "R8");
    bus_stop();
    expect_after_stop(0, "R4");

    // R9: repeated START abandons a started write
    expq.push_back({1'b0, 4'h2, 2'b00, 2'b01, 6'h00});
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R2");
    send_byte(8'hA5, 1'b1, 1'b0, "R9");
    bus_start();
    send_byte(8'h5A, 1'b1, 1'b0, "R9");
    send_byte(8'h21, 1'b1, 1'b0, "R9");
    bus_stop();
    expect_after_stop(0, "R9");

    waitc(20);
    check(expq.size() == 0, "R8", expq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule